// File: doc/BRIEF.md
# Part Number String Reader

This block produces a product part number as a byte string. It drives a word-read port toward non-volatile storage and writes the result one byte per cycle into a buffer owned by the caller. A single start pulse begins a run. The block first fetches two header words from fixed word addresses 0x0008 and 0x0009. The first header word decides the layout. If it equals the guard value 0xFAFA, the second header word is a pointer. Any other value means the two header words hold the part number directly as packed nibbles.

In the nibble layout, the block expands the two words into eleven bytes: upper-case hexadecimal characters with a dash inserted, followed by a terminating zero byte. In the pointer layout, the block reads a length word at the pointer. That length counts itself. The block then copies the packed character words that follow, high byte first, and ends with a zero byte. Before writing anything, it checks the caller's buffer size (a runtime input) and the length word. A failed read at any point stops the run.

When the run ends, `done` pulses for one cycle and `errCode` gives the outcome: 0 success, 1 buffer too small, 2 invalid length, 3 read failure. `bufSize` must stay steady while `busy` is high.

Top module: `partstr_top`

## Requirements
- R1: A run reads word 0x0008 and then word 0x0009. The pointer layout is chosen only when the first word equals exactly 0xFAFA; every other value selects the nibble layout.
- R2: In the nibble layout, a `bufSize` below 11 ends the run with errCode 1 and no byte written. A `bufSize` of exactly 11 is accepted.
- R3: The nibble layout writes indices 0..10 in this order: the four nibbles of word 0x0008 (most significant first), the two upper nibbles of word 0x0009, the dash 0x2D, the character '0', the two lower nibbles of word 0x0009, and 0x00. It then ends with errCode 0.
- R4: Each nibble value v below 10 becomes 0x30+v. Each value from 10 to 15 becomes 0x41+(v-10). The dash and the final zero byte are not converted.
- R5: In the pointer layout, a length word of 0x0000 or 0xFFFF ends the run with errCode 2 and no byte written. This check is made before the buffer size check.
- R6: In the pointer layout, a `bufSize` below 2*length-1 ends the run with errCode 1 and no byte written. A `bufSize` equal to 2*length-1 is accepted.
- R7: In the pointer layout, the block reads length-1 words at pointer+1 upward. For each word it writes the high byte and then the low byte, at consecutive indices starting at 0. A final 0x00 follows, so 2*length-1 bytes are written in total. A length of 1 writes only the 0x00.
- R8: A read that returns `rdFail` with `rdAck` ends the run with errCode 3. Bytes written before the failure stay written, and no terminating zero is written.
- R9: `done` is high for exactly one cycle per run, with `errCode` valid in that cycle. `busy` is high from the cycle after start until the done cycle. A start pulse that arrives while busy is ignored.
- R10: `rdReq` stays high with `rdAddr` unchanged until `rdAck` arrives. No byte is written in a cycle where a read is requested, and no write index reaches `bufSize`.
- R11: After reset, `busy`, `done`, `outWe` and `rdReq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle |
| bufSize | input | SIZE_W | Output buffer capacity in bytes |
| rdReq | output | 1 | Word read request, held until acknowledged |
| rdAddr | output | ADDR_W | Word address of the request |
| rdAck | input | 1 | Read response valid |
| rdData | input | 16 | Read data word |
| rdFail | input | 1 | Read failed, qualified by rdAck |
| outWe | output | 1 | Byte write strobe |
| outIdx | output | IDX_W | Byte index in the buffer |
| outByte | output | 8 | Byte value |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| errCode | output | 2 | Outcome code, valid with done |

## Verification
The nibble layout is tried with words whose nibbles include 0, 9, A and F. This separates the two conversion ranges and their edges, and a first word of 0xFAFB shows that a near-guard value still selects the nibble layout. The pointer layout is tried with lengths of 1, 2, 4 and 20. These show a lone terminator, short and long copies, and byte order within each word. Buffer sizes are placed exactly at and one below each layout's limit to pin down the comparison. A length of 0xFFFF combined with a zero buffer size shows that the length check wins. Read failures are injected at each header word, at the length word, and at a data word, which shows that a run stops where the failure occurs.

// File: rtl/partstr_pkg.sv
package partstr_pkg;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_NOSPACE = 2'd1,
    ERR_SECTION = 2'd2,
    ERR_READ    = 2'd3
  } errCode_t;

  typedef enum logic [1:0] {
    SEL_LEG,
    SEL_HI,
    SEL_LO,
    SEL_NUL
  } byteSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic addrHdr0;
    logic addrHdr1;
    logic addrPtr;
    logic addrInc;
    logic ldW0;
    logic ldW1;
    logic ldRem;
    logic decRem;
    logic ldCur;
    logic clrIdx;
    logic incIdx;
  } dpCtl_t;

  localparam logic [7:0] CH_DASH = 8'h2D;
  localparam logic [7:0] CH_NUL  = 8'h00;
  localparam int LEG_BYTES = 11;

  function automatic logic [7:0] nibToAscii(input logic [3:0] v);
    if (v < 4'd10) return 8'h30 + {4'h0, v};
    else           return 8'h37 + {4'h0, v};
  endfunction

endpackage

// File: rtl/partstr_dp.sv
module partstr_dp
  import partstr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 16,
  parameter int IDX_W  = 17,
  parameter logic [15:0] HDR0_ADDR = 16'h0008,
  parameter logic [15:0] HDR1_ADDR = 16'h0009,
  parameter logic [15:0] GUARD     = 16'hFAFA
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  byteSel_t          byteSel,
  input  logic [15:0]       rdData,
  input  logic [SIZE_W-1:0] bufSize,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [IDX_W-1:0]  outIdx,
  output logic [7:0]        outByte,
  output logic              isGuard,
  output logic              legFits,
  output logic              lenBad,
  output logic              ptrFits,
  output logic              remZero,
  output logic              legLast
);

  localparam int CMP_W = ((SIZE_W > 17) ? SIZE_W : 17) + 1;

  logic [ADDR_W-1:0] addrReg;
  logic [15:0]       w0Reg, w1Reg, remReg, curReg;
  logic [IDX_W-1:0]  idxReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      w0Reg   <= '0;
      w1Reg   <= '0;
      remReg  <= '0;
      curReg  <= '0;
      idxReg  <= '0;
    end else begin
      if (ctl.addrHdr0)     addrReg <= ADDR_W'(HDR0_ADDR);
      else if (ctl.addrHdr1) addrReg <= ADDR_W'(HDR1_ADDR);
      else if (ctl.addrPtr)  addrReg <= ADDR_W'(w1Reg);
      else if (ctl.addrInc)  addrReg <= addrReg + ADDR_W'(1);
      if (ctl.ldW0)  w0Reg  <= rdData;
      if (ctl.ldW1)  w1Reg  <= rdData;
      if (ctl.ldCur) curReg <= rdData;
      if (ctl.ldRem)       remReg <= rdData;
      else if (ctl.decRem) remReg <= remReg - 16'd1;
      if (ctl.clrIdx)      idxReg <= '0;
      else if (ctl.incIdx) idxReg <= idxReg + IDX_W'(1);
    end
  end

  // buffer-size needs
  logic [CMP_W-1:0] needBytes;
  assign needBytes = CMP_W'({remReg, 1'b0}) - CMP_W'(1);
  assign ptrFits   = CMP_W'(bufSize) >= needBytes;
  assign legFits   = CMP_W'(bufSize) >= CMP_W'(LEG_BYTES);
  assign lenBad    = (remReg == 16'h0000) || (remReg == 16'hFFFF);
  assign remZero   = (remReg == 16'h0000);
  assign isGuard   = (w0Reg == GUARD);
  assign legLast   = (idxReg == IDX_W'(LEG_BYTES - 1));

  // nibble layout byte for the current index
  logic [3:0] legNib;
  logic [7:0] legByte;
  always_comb begin
    unique case (idxReg[3:0])
      4'd0:    legNib = w0Reg[15:12];
      4'd1:    legNib = w0Reg[11:8];
      4'd2:    legNib = w0Reg[7:4];
      4'd3:    legNib = w0Reg[3:0];
      4'd4:    legNib = w1Reg[15:12];
      4'd5:    legNib = w1Reg[11:8];
      4'd8:    legNib = w1Reg[7:4];
      4'd9:    legNib = w1Reg[3:0];
      default: legNib = 4'h0;
    endcase
    if (idxReg[3:0] == 4'd6)       legByte = CH_DASH;
    else if (idxReg[3:0] == 4'd10) legByte = CH_NUL;
    else                           legByte = nibToAscii(legNib);
  end

  always_comb begin
    unique case (byteSel)
      SEL_LEG: outByte = legByte;
      SEL_HI:  outByte = curReg[15:8];
      SEL_LO:  outByte = curReg[7:0];
      default: outByte = CH_NUL;
    endcase
  end

  assign rdAddr = addrReg;
  assign outIdx = idxReg;

  // R7: remaining count never wraps below zero
  assert_rem_underflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.decRem |-> (remReg != 16'h0000));

endmodule

// File: rtl/partstr_ctrl.sv
module partstr_ctrl
  import partstr_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     rdAck,
  input  logic     rdFail,
  input  logic     isGuard,
  input  logic     legFits,
  input  logic     lenBad,
  input  logic     ptrFits,
  input  logic     remZero,
  input  logic     legLast,
  output dpCtl_t   ctl,
  output byteSel_t byteSel,
  output logic     rdReq,
  output logic     outWe,
  output logic     busy,
  output logic     done,
  output logic [1:0] errCode
);

  typedef enum logic [3:0] {
    S_IDLE, S_RDH0, S_RDH1, S_PICK, S_LEG, S_RDLEN, S_LENCHK,
    S_LOOP, S_RDW, S_EMHI, S_EMLO, S_NUL, S_FIN
  } state_t;

  state_t   state, nxt;
  errCode_t errReg, errNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      errReg <= ERR_NONE;
    end else begin
      state  <= nxt;
      errReg <= errNxt;
    end
  end

  always_comb begin
    nxt     = state;
    errNxt  = errReg;
    ctl     = '0;
    byteSel = SEL_LEG;
    rdReq   = 1'b0;
    outWe   = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.addrHdr0 = 1'b1;
        ctl.clrIdx   = 1'b1;
        errNxt       = ERR_NONE;
        nxt          = S_RDH0;
      end
      S_RDH0: begin
        rdReq = 1'b1;
        if (rdAck) begin
          if (rdFail) begin errNxt = ERR_READ; nxt = S_FIN; end
          else begin ctl.ldW0 = 1'b1; ctl.addrHdr1 = 1'b1; nxt = S_RDH1; end
        end
      end
      S_RDH1: begin
        rdReq = 1'b1;
        if (rdAck) begin
          if (rdFail) begin errNxt = ERR_READ; nxt = S_FIN; end
          else begin ctl.ldW1 = 1'b1; nxt = S_PICK; end
        end
      end
      S_PICK: begin
        if (isGuard) begin ctl.addrPtr = 1'b1; nxt = S_RDLEN; end
        else if (legFits) nxt = S_LEG;
        else begin errNxt = ERR_NOSPACE; nxt = S_FIN; end
      end
      S_LEG: begin
        outWe      = 1'b1;
        byteSel    = SEL_LEG;
        ctl.incIdx = 1'b1;
        if (legLast) nxt = S_FIN;
      end
      S_RDLEN: begin
        rdReq = 1'b1;
        if (rdAck) begin
          if (rdFail) begin errNxt = ERR_READ; nxt = S_FIN; end
          else begin ctl.ldRem = 1'b1; nxt = S_LENCHK; end
        end
      end
      S_LENCHK: begin
        if (lenBad) begin errNxt = ERR_SECTION; nxt = S_FIN; end
        else if (!ptrFits) begin errNxt = ERR_NOSPACE; nxt = S_FIN; end
        else begin ctl.decRem = 1'b1; ctl.addrInc = 1'b1; nxt = S_LOOP; end
      end
      S_LOOP: nxt = remZero ? S_NUL : S_RDW;
      S_RDW: begin
        rdReq = 1'b1;
        if (rdAck) begin
          if (rdFail) begin errNxt = ERR_READ; nxt = S_FIN; end
          else begin ctl.ldCur = 1'b1; ctl.decRem = 1'b1; nxt = S_EMHI; end
        end
      end
      S_EMHI: begin
        outWe = 1'b1; byteSel = SEL_HI; ctl.incIdx = 1'b1; nxt = S_EMLO;
      end
      S_EMLO: begin
        outWe = 1'b1; byteSel = SEL_LO; ctl.incIdx = 1'b1;
        ctl.addrInc = 1'b1; nxt = S_LOOP;
      end
      S_NUL: begin
        outWe = 1'b1; byteSel = SEL_NUL; nxt = S_FIN;
      end
      S_FIN: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign busy    = (state != S_IDLE);
  assign done    = (state == S_FIN);
  assign errCode = errReg;

  // R9: one-cycle completion pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: no byte write while a read is outstanding
  assert_write_no_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    outWe |-> !rdReq);

endmodule

// File: rtl/partstr_top.sv
module partstr_top
  import partstr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 16,
  parameter int IDX_W  = 17,
  parameter logic [15:0] HDR0_ADDR = 16'h0008,
  parameter logic [15:0] HDR1_ADDR = 16'h0009,
  parameter logic [15:0] GUARD     = 16'hFAFA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [SIZE_W-1:0] bufSize,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAck,
  input  logic [15:0]       rdData,
  input  logic              rdFail,
  output logic              outWe,
  output logic [IDX_W-1:0]  outIdx,
  output logic [7:0]        outByte,
  output logic              busy,
  output logic              done,
  output logic [1:0]        errCode
);

  dpCtl_t   ctl;
  byteSel_t byteSel;
  logic isGuard, legFits, lenBad, ptrFits, remZero, legLast;

  partstr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rdAck(rdAck), .rdFail(rdFail),
    .isGuard(isGuard), .legFits(legFits), .lenBad(lenBad), .ptrFits(ptrFits),
    .remZero(remZero), .legLast(legLast), .ctl(ctl), .byteSel(byteSel),
    .rdReq(rdReq), .outWe(outWe), .busy(busy), .done(done), .errCode(errCode)
  );

  partstr_dp #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .IDX_W(IDX_W),
    .HDR0_ADDR(HDR0_ADDR), .HDR1_ADDR(HDR1_ADDR), .GUARD(GUARD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .byteSel(byteSel), .rdData(rdData),
    .bufSize(bufSize), .rdAddr(rdAddr), .outIdx(outIdx), .outByte(outByte),
    .isGuard(isGuard), .legFits(legFits), .lenBad(lenBad), .ptrFits(ptrFits),
    .remZero(remZero), .legLast(legLast)
  );

  // R10: request held with a steady address until acknowledged
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> (rdReq && $stable(rdAddr)));

  // R10: never write past the caller's buffer
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    outWe |-> (32'(outIdx) < 32'(bufSize)));

  // R9: back to idle right after completion
  assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

// File: tb/sim_partstr_top.sv
module sim_partstr_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] bufSize = 16'd0;
  logic        rdReq;
  logic [15:0] rdAddr;
  logic        rdAck = 1'b0;
  logic [15:0] rdData = 16'h0;
  logic        rdFail = 1'b0;
  logic        outWe;
  logic [16:0] outIdx;
  logic [7:0]  outByte;
  logic        busy, done;
  logic [1:0]  errCode;

  always #5 clk = ~clk;

  partstr_top u0 (
    .clk(clk), .rstN(rstN), .start(start), .bufSize(bufSize),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .rdData(rdData),
    .rdFail(rdFail), .outWe(outWe), .outIdx(outIdx), .outByte(outByte),
    .busy(busy), .done(done), .errCode(errCode)
  );

  int total = 0;
  int bad = 0;

  // storage model: one-cycle read latency, failure at one chosen address
  logic [15:0] mem [0:63];
  logic [15:0] failAddr = 16'hFFFF;
  always @(negedge clk) begin
    if (!rstN) rdAck <= 1'b0;
    else if (rdReq && !rdAck) begin
      rdAck  <= 1'b1;
      rdData <= mem[rdAddr[5:0]];
      rdFail <= (rdAddr == failAddr);
    end else rdAck <= 1'b0;
  end

  // byte capture
  logic [7:0] wrBuf [0:63];
  int wrCnt = 0;
  int doneCnt = 0;
  bit orderBad = 0;
  always @(negedge clk) begin
    if (outWe) begin
      if (int'(outIdx) != wrCnt) orderBad = 1;
      wrBuf[outIdx[5:0]] = outByte;
      wrCnt = wrCnt + 1;
    end
    if (done) doneCnt = doneCnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // w0, w1, length word, bufSize, failing address
  localparam int NV = 15;
  localparam logic [79:0] VEC [0:NV-1] = '{
    {16'h1A2B, 16'h3C4D, 16'h0000, 16'd11,   16'hFFFF},
    {16'h09F0, 16'hE5A6, 16'h0000, 16'd64,   16'hFFFF},
    {16'h1A2B, 16'h3C4D, 16'h0000, 16'd10,   16'hFFFF},
    {16'hFAFB, 16'h0020, 16'h0004, 16'd11,   16'hFFFF},
    {16'hFAFA, 16'h0020, 16'h0004, 16'd7,    16'hFFFF},
    {16'hFAFA, 16'h0020, 16'h0004, 16'd6,    16'hFFFF},
    {16'hFAFA, 16'h0020, 16'h0000, 16'd64,   16'hFFFF},
    {16'hFAFA, 16'h0020, 16'hFFFF, 16'd0,    16'hFFFF},
    {16'hFAFA, 16'h0020, 16'h0001, 16'd1,    16'hFFFF},
    {16'hFAFA, 16'h0020, 16'h0005, 16'd64,   16'h0022},
    {16'hFAFA, 16'h0020, 16'h0003, 16'd64,   16'h0008},
    {16'hFAFA, 16'h0020, 16'h0003, 16'd64,   16'h0020},
    {16'h1234, 16'h5678, 16'h0000, 16'd64,   16'h0009},
    {16'hFAFA, 16'h0020, 16'h0014, 16'd39,   16'hFFFF},
    {16'hFAFA, 16'h0020, 16'h0002, 16'hFFFF, 16'hFFFF}
  };

  // reference outcome
  int       expErr, expCnt;
  logic [7:0] expB [0:63];

  function automatic logic [7:0] hexCh(input logic [3:0] v);
    return (v <= 4'd9) ? (8'd48 + 8'(v)) : (8'd65 + 8'(v) - 8'd10);
  endfunction

  task automatic refModel(input logic [15:0] w0, input logic [15:0] w1,
                          input logic [15:0] bsz, input logic [15:0] fa);
    logic [15:0] len;
    expErr = 0; expCnt = 0;
    if (fa == 16'h0008 || fa == 16'h0009) begin expErr = 3; return; end
    if (w0 != 16'hFAFA) begin
      if (bsz < 16'd11) begin expErr = 1; return; end
      expB[0] = hexCh(w0[15:12]); expB[1] = hexCh(w0[11:8]);
      expB[2] = hexCh(w0[7:4]);   expB[3] = hexCh(w0[3:0]);
      expB[4] = hexCh(w1[15:12]); expB[5] = hexCh(w1[11:8]);
      expB[6] = 8'h2D;            expB[7] = 8'h30;
      expB[8] = hexCh(w1[7:4]);   expB[9] = hexCh(w1[3:0]);
      expB[10] = 8'h00;
      expCnt = 11;
      return;
    end
    if (fa == w1) begin expErr = 3; return; end
    len = mem[w1[5:0]];
    if (len == 16'h0000 || len == 16'hFFFF) begin expErr = 2; return; end
    if (int'(bsz) < 2 * int'(len) - 1) begin expErr = 1; return; end
    for (int k = 0; k < int'(len) - 1; k++) begin
      logic [15:0] a;
      a = w1 + 16'd1 + 16'(k);
      if (a == fa) begin expErr = 3; return; end
      expB[expCnt]     = mem[a[5:0]][15:8];
      expB[expCnt + 1] = mem[a[5:0]][7:0];
      expCnt += 2;
    end
    expB[expCnt] = 8'h00;
    expCnt++;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone(output bit seen);
    seen = 0;
    for (int c = 0; c < 3000; c++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic runVec(input int i);
    logic [15:0] w0, w1, ln, bs, fa;
    bit seen, same;
    {w0, w1, ln, bs, fa} = VEC[i];
    for (int a = 0; a < 64; a++) mem[a] = 16'h4142 + 16'(a) * 16'h0202;
    mem[8] = w0; mem[9] = w1; mem[32] = ln;
    bufSize = bs; failAddr = fa;
    refModel(w0, w1, bs, fa);
    wrCnt = 0; orderBad = 0;
    pulseStart();
    waitDone(seen);
    // R8 R5 R6 R2: outcome code
    check(seen && errCode == 2'(expErr), "R2/R5/R6/R8", $sformatf("vec%0d errCode", i),
          int'(errCode), expErr);
    // R7 R3: byte count
    check(wrCnt == expCnt, "R3/R7", $sformatf("vec%0d byteCount", i), wrCnt, expCnt);
    same = !orderBad;
    for (int k = 0; k < expCnt && k < 64; k++) if (wrBuf[k] !== expB[k]) same = 0;
    // R1 R3 R4 R7: string content and order
    check(same, "R1/R3/R4/R7", $sformatf("vec%0d content", i), int'(same), 1);
    @(negedge clk);
    // R9: done lasts a single cycle
    check(!done && !busy, "R9", $sformatf("vec%0d done width", i), int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen;
    int d0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!busy && !done && !outWe && !rdReq, "R11", "reset outputs",
          {busy, done, outWe, rdReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !rdReq, "R11", "idle after reset", {busy, rdReq}, 0);

    for (int i = 0; i < NV; i++) runVec(i);

    // R9: start while busy is ignored
    for (int a = 0; a < 64; a++) mem[a] = 16'h4142 + 16'(a) * 16'h0202;
    mem[8] = 16'hFAFA; mem[9] = 16'h0020; mem[32] = 16'h0006;
    bufSize = 16'd64; failAddr = 16'hFFFF;
    refModel(16'hFAFA, 16'h0020, 16'd64, 16'hFFFF);
    wrCnt = 0; orderBad = 0;
    d0 = doneCnt;
    pulseStart();
    check(busy, "R9", "busy after start", int'(busy), 1);
    repeat (4) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    waitDone(seen);
    check(seen && errCode == 2'd0 && wrCnt == expCnt, "R9", "run with extra start",
          wrCnt, expCnt);
    repeat (40) @(negedge clk);
    check(doneCnt == d0 + 1 && !busy, "R9", "no second run", doneCnt - d0, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule